// File: doc/BRIEF.md
# Loop Replay Buffer with Front-End Gating

This block sits between the decode stage and the back end of a core. While it is idle, it forwards each decoded operation, together with its PC and branch information, without change and with no added cycle. When a taken branch jumps back to a PC that is no further than `DEPTH` operations behind it, the block records the next pass through that loop body. If the pass is a run of consecutive PCs that ends with the same branch, taken back to the loop head, the block switches to replay. During replay it supplies the stored operations to the back end in a loop. It also holds fetch, decode and branch prediction disabled, with their clocks gated.

During replay the loop-closing branch is always presented as taken. The back end resolves the real outcome. A mispredicted exit, a flush or an exception reaches the block on `redirect`. That input ends replay and reopens the front end in the same cycle, and it also discards the stored loop. The output side uses a valid/ready handshake. While the back end is not ready, replay holds its position.

PCs count operations, so consecutive operations differ by one.

Top module: `loop_replay_buffer`

## Requirements
- R1: An accepted operation with `in_br=1`, `in_taken=1`, `in_tgt <= in_pc` and `in_pc - in_tgt + 1 <= DEPTH` starts a capture. Forward-taken branches, not-taken branches and plain operations never start one.
- R2: Outside replay, and with `redirect` low, `out_valid`, `out_pc`, `out_uop`, `out_br`, `out_taken` and `out_tgt` equal the matching inputs in the same cycle, and `in_ready` equals `out_ready`.
- R3: During a capture, the k-th accepted operation (k counted from 0) must carry PC `head + k`, where `head` is the loop head. The first operation that breaks this order ends the capture with no replay.
- R4: Replay starts in the cycle after the capture accepts the operation at the loop-end PC, and only if that operation is a taken branch whose target is the head. Any other operation at the loop-end PC ends the capture with no replay.
- R5: Replay presents PCs head, head+1, …, end, then head again, each with the `out_uop` that was recorded for it. The operation at the end PC shows `out_br=1`, `out_taken=1` and `out_tgt=head`.
- R6: During replay, a cycle with `out_ready=0` leaves the presented operation unchanged in the next cycle.
- R7: During replay with `redirect` low, all three bits of `fe_en` are 0, all three bits of `fe_gate` are 1, `in_ready` is 0, and input operations are ignored. Bit 0 controls fetch, bit 1 decode and bit 2 branch prediction.
- R8: While `redirect` is high, `fe_en` is all ones and `out_valid` is 0, in the same cycle. From the next cycle the block passes input through, and the old loop is never replayed again without a new capture.
- R9: A `redirect` during a capture discards it. An operation accepted after that can only start a new capture.
- R10: A loop body of exactly `DEPTH` operations is captured and replayed. One of `DEPTH+1` operations is never captured. A branch that targets its own PC forms a one-operation loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded operation available |
| in_ready | output | 1 | Operation accepted when high together with in_valid |
| in_pc | input | PC_W | PC of the operation, counted in operations |
| in_uop | input | UOP_W | Decoded operation payload |
| in_br | input | 1 | Operation is a branch |
| in_taken | input | 1 | Branch predicted taken |
| in_tgt | input | PC_W | Branch target PC |
| redirect | input | 1 | Back-end redirect, flush or exception |
| out_valid | output | 1 | Operation presented to the back end |
| out_ready | input | 1 | Back end accepts the operation |
| out_pc | output | PC_W | PC of the presented operation |
| out_uop | output | UOP_W | Presented payload |
| out_br | output | 1 | Presented operation is a branch |
| out_taken | output | 1 | Presented branch direction |
| out_tgt | output | PC_W | Presented branch target |
| fe_en | output | 3 | Enables for fetch, decode and branch prediction |
| fe_gate | output | 3 | Clock-gate requests for the same three stages |

## Verification
The embedded properties check, on every cycle, the rules that follow from the current state:
- forwarding outside replay;
- the three stage controls switching together;
- a quiet front end during replay;
- the same-cycle reopening on a redirect;
- hold on back-pressure;
- indices staying inside the captured body;
- replay entered only from a completed capture.

Other behaviours need whole sequences and are shown only by the bench's scenarios:
- the exact PC and payload order of a replayed loop across several wraps;
- the rejection of broken, over-long or non-closing captures;
- the one-operation loop;
- the loss of the stored loop after a redirect.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_FILL = 2'd1,
    LB_PLAY = 2'd2
  } lb_state_e;

  localparam int unsigned FE_STAGES = 3;

  // True when a taken branch at br_pc jumping to tgt_pc closes a body of at
  // most depth operations (the branch itself included).
  function automatic logic loop_fits(input logic [31:0] br_pc,
                                     input logic [31:0] tgt_pc,
                                     input int unsigned depth);
    return (tgt_pc <= br_pc) && ((br_pc - tgt_pc) < depth);
  endfunction

  // Number of operations from tgt_pc up to and including br_pc.
  function automatic logic [31:0] loop_span(input logic [31:0] br_pc,
                                            input logic [31:0] tgt_pc);
    return br_pc - tgt_pc + 32'd1;
  endfunction

  // Advance a position inside a body of len entries, wrapping to zero.
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] len);
    return ((idx + 32'd1) >= len) ? 32'd0 : idx + 32'd1;
  endfunction

endpackage

// File: rtl/lb_detect.sv
module lb_detect #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 6
) (
  input  logic [PC_W-1:0]  br_pc,
  input  logic [PC_W-1:0]  tgt_pc,
  input  logic             is_br,
  input  logic             taken,
  output logic             hit,
  output logic [LEN_W-1:0] span
);

  logic fits;

  always_comb begin
    fits = lb_pkg::loop_fits(32'(br_pc), 32'(tgt_pc), DEPTH);
    hit  = is_br && taken && fits;
    span = LEN_W'(lb_pkg::loop_span(32'(br_pc), 32'(tgt_pc)));
  end

endmodule

// File: rtl/lb_store.sv
module lb_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 34,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);

  logic [DEPTH*W-1:0] flat;

  // One register per slot; validity is tracked by the controller.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == IDX_W'(g))) q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  assign rdata = flat[raddr*W +: W];

endmodule

// File: rtl/lb_gate.sv
module lb_gate #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [STAGES-1:0] fe_en,
  output logic [STAGES-1:0] fe_gate
);

  // Each front-end stage gets its own enable and gate request; all follow
  // the same hold condition so they switch off and on together.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign fe_en[s]   = !hold;
    assign fe_gate[s] = hold;
  end

  AST_STAGES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_en == '0) || (fe_en == '1)); // R7

endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl import lb_pkg::*; #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             redirect,
  input  logic             out_ready,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_br,
  input  logic             in_taken,
  input  logic [PC_W-1:0]  in_tgt,
  input  logic             cand,
  input  logic [LEN_W-1:0] cand_len,
  output logic             play,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  head_pc
);

  lb_state_e        state_q, state_d;
  logic [IDX_W-1:0] wr_q, wr_d, rd_q, rd_d, rd_nx;
  logic [PC_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [PC_W-1:0]  want_pc;

  // Named internal events, used by the next-state logic and the properties.
  logic ev_arm, ev_match, ev_slip, ev_end, ev_close, ev_refuse, ev_step;

  assign want_pc   = head_q + PC_W'(wr_q);
  assign rd_nx     = IDX_W'(ring_next(32'(rd_q), 32'(len_q)));

  assign ev_arm    = (state_q == LB_IDLE) && fire && cand;
  assign ev_match  = (state_q == LB_FILL) && fire && (in_pc == want_pc);
  assign ev_slip   = (state_q == LB_FILL) && fire && (in_pc != want_pc);
  assign ev_end    = ev_match && (in_pc == tail_q);
  assign ev_close  = ev_end && in_br && in_taken && (in_tgt == head_q);
  assign ev_refuse = ev_end && !ev_close;
  assign ev_step   = (state_q == LB_PLAY) && out_ready && !redirect;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    rd_d    = rd_q;
    head_d  = head_q;
    tail_d  = tail_q;
    len_d   = len_q;
    if (redirect) begin
      state_d = LB_IDLE;
    end else begin
      unique case (state_q)
        LB_IDLE: if (ev_arm) begin
          state_d = LB_FILL;
          head_d  = in_tgt;
          tail_d  = in_pc;
          len_d   = cand_len;
          wr_d    = '0;
        end
        LB_FILL: begin
          if (ev_slip || ev_refuse) begin
            state_d = LB_IDLE;
          end else if (ev_close) begin
            state_d = LB_PLAY;
            rd_d    = '0;
          end else if (ev_match) begin
            wr_d = wr_q + 1'b1;
          end
        end
        LB_PLAY: if (ev_step) rd_d = rd_nx;
        default: state_d = LB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LB_IDLE;
      wr_q    <= '0;
      rd_q    <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      len_q   <= len_d;
    end
  end

  assign play    = (state_q == LB_PLAY);
  assign wr_en   = ev_match;
  assign wr_idx  = wr_q;
  assign rd_idx  = rd_q;
  assign head_pc = head_q;

  AST_PLAY_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == LB_PLAY) |-> $past(ev_close)); // R4

  AST_SLIP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slip |=> (state_q == LB_IDLE)); // R3

  AST_STALL_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LB_PLAY) && !out_ready && !redirect) |=>
      ((state_q == LB_PLAY) && $stable(rd_q))); // R6

  AST_REDIRECT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (state_q == LB_IDLE)); // R8

  AST_READ_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LB_PLAY) |-> (32'(rd_q) < 32'(len_q))); // R5

  AST_FILL_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LB_FILL) |-> (32'(wr_q) < 32'(len_q))); // R10

endmodule

// File: rtl/loop_replay_buffer.sv
module loop_replay_buffer import lb_pkg::*; #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned UOP_W = 16,
  parameter int unsigned PC_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PC_W-1:0]      in_pc,
  input  logic [UOP_W-1:0]     in_uop,
  input  logic                 in_br,
  input  logic                 in_taken,
  input  logic [PC_W-1:0]      in_tgt,
  input  logic                 redirect,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PC_W-1:0]      out_pc,
  output logic [UOP_W-1:0]     out_uop,
  output logic                 out_br,
  output logic                 out_taken,
  output logic [PC_W-1:0]      out_tgt,
  output logic [FE_STAGES-1:0] fe_en,
  output logic [FE_STAGES-1:0] fe_gate
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LEN_W = $clog2(DEPTH + 1);
  localparam int unsigned ENT_W = UOP_W + 2 + PC_W;

  logic             fire, play, cand, wr_en, play_hold;
  logic [LEN_W-1:0] cand_len;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [PC_W-1:0]  head_pc, rp_pc, rp_tgt;
  logic [ENT_W-1:0] wr_ent, rd_ent;
  logic [UOP_W-1:0] rp_uop;
  logic             rp_br, rp_taken;

  assign in_ready  = !play && out_ready;
  assign fire      = in_valid && in_ready && !redirect;
  assign play_hold = play && !redirect;

  lb_detect #(.PC_W(PC_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_detect (
    .br_pc(in_pc), .tgt_pc(in_tgt), .is_br(in_br), .taken(in_taken),
    .hit(cand), .span(cand_len)
  );

  lb_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .redirect(redirect),
    .out_ready(out_ready), .in_pc(in_pc), .in_br(in_br),
    .in_taken(in_taken), .in_tgt(in_tgt), .cand(cand), .cand_len(cand_len),
    .play(play), .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .head_pc(head_pc)
  );

  assign wr_ent = {in_uop, in_br, in_taken, in_tgt};

  lb_store #(.DEPTH(DEPTH), .W(ENT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_ent),
    .raddr(rd_idx), .rdata(rd_ent)
  );

  assign {rp_uop, rp_br, rp_taken, rp_tgt} = rd_ent;
  assign rp_pc = head_pc + PC_W'(rd_idx);

  always_comb begin
    out_valid = redirect ? 1'b0 : (play ? 1'b1 : in_valid);
    out_pc    = play ? rp_pc    : in_pc;
    out_uop   = play ? rp_uop   : in_uop;
    out_br    = play ? rp_br    : in_br;
    out_taken = play ? rp_taken : in_taken;
    out_tgt   = play ? rp_tgt   : in_tgt;
  end

  lb_gate #(.STAGES(FE_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .hold(play_hold),
    .fe_en(fe_en), .fe_gate(fe_gate)
  );

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!play && !redirect) |->
      ((out_valid == in_valid) && (out_pc == in_pc) && (in_ready == out_ready))); // R2

  AST_FRONT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (play && !redirect) |-> ((fe_en == '0) && (fe_gate == '1) && !in_ready)); // R7

  AST_FLUSH_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ((fe_en == '1) && !out_valid)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (play && out_valid && !out_ready && !redirect) |=>
      ($stable(out_pc) && $stable(out_uop))); // R6

endmodule

// File: tb/loop_replay_buffer_test.sv
module loop_replay_buffer_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_br, in_taken, redirect;
  logic        out_valid, out_ready, out_br, out_taken;
  logic [15:0] in_pc, in_uop, in_tgt, out_pc, out_uop, out_tgt;
  logic [2:0]  fe_en, fe_gate;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  loop_replay_buffer #(.DEPTH(DEPTH), .UOP_W(16), .PC_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_uop(in_uop), .in_br(in_br), .in_taken(in_taken),
    .in_tgt(in_tgt), .redirect(redirect), .out_valid(out_valid),
    .out_ready(out_ready), .out_pc(out_pc), .out_uop(out_uop),
    .out_br(out_br), .out_taken(out_taken), .out_tgt(out_tgt),
    .fe_en(fe_en), .fe_gate(fe_gate)
  );

  function automatic logic [15:0] uop_of(input logic [15:0] pc);
    return (pc * 16'd40503) ^ 16'h5a3c;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Present one operation while not replaying; expect same-cycle forwarding.
  task automatic pass_op(input logic [15:0] pc, input logic br, input logic tk,
                         input logic [15:0] tgt, input string tag);
    in_valid = 1'b1; in_pc = pc; in_uop = uop_of(pc);
    in_br = br; in_taken = tk; in_tgt = tgt; out_ready = 1'b1;
    #1;
    chk(out_valid && in_ready, {tag, " R2 fwd handshake"}, {out_valid, in_ready}, 2'b11);
    chk(out_pc == pc && out_uop == uop_of(pc), {tag, " R2 fwd pc"}, out_pc, pc);
    chk(out_tgt == tgt && out_br == br && out_taken == tk, {tag, " R2 fwd branch"}, out_tgt, tgt);
    chk(fe_en == 3'b111 && fe_gate == 3'b000, {tag, " R7 front open"}, fe_en, 3'b111);
    @(negedge clk);
  endtask

  // Idle input for one cycle and confirm nothing is replayed.
  task automatic expect_quiet(input string tag);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(!out_valid && fe_en == 3'b111, {tag, " no replay"}, {out_valid, fe_en}, 4'b0111);
    @(negedge clk);
  endtask

  // Candidate branch, then one full clean pass of the body.
  task automatic capture(input logic [15:0] head, input int len);
    logic [15:0] tail = head + 16'(len - 1);
    pass_op(tail, 1'b1, 1'b1, head, "R1 arm");
    for (int k = 0; k < len; k++) begin
      if (k == len - 1) pass_op(head + 16'(k), 1'b1, 1'b1, head, "R4 close");
      else              pass_op(head + 16'(k), 1'b0, 1'b0, 16'h0, "R3 body");
    end
  endtask

  task automatic replay_run(input logic [15:0] head, input int len, input int steps);
    int k = 0;
    logic [15:0] e;
    while (k < steps) begin
      out_ready = ($urandom_range(0, 9) < 7);
      in_valid = 1'b1; in_pc = 16'hBEEF; in_uop = 16'h1111;
      in_br = 1'b1; in_taken = 1'b1; in_tgt = 16'h0;
      #1;
      e = head + 16'(k % len);
      chk(out_valid, out_ready ? "R5 valid" : "R6 valid hold", out_valid, 1);
      chk(out_pc == e, out_ready ? "R5 pc order" : "R6 pc hold", out_pc, e);
      chk(out_uop == uop_of(e), "R5 payload", out_uop, uop_of(e));
      chk(fe_en == 3'b000 && fe_gate == 3'b111 && !in_ready, "R7 front gated",
          {fe_en, fe_gate, in_ready}, 7'b0001110);
      if ((k % len) == len - 1)
        chk(out_br && out_taken && out_tgt == head, "R5 loop branch taken",
            out_tgt, head);
      if (out_ready) k++;
      @(negedge clk);
    end
  endtask

  task automatic do_redirect(input string tag);
    redirect = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(fe_en == 3'b111 && fe_gate == 3'b000, {tag, " R8 same-cycle reopen"}, fe_en, 3'b111);
    chk(!out_valid, {tag, " R8 valid low"}, out_valid, 0);
    @(negedge clk);
    redirect = 1'b0;
  endtask

  initial begin
    logic [15:0] pc, tgt, h;
    int len, nst, seedv;
    seedv = $urandom(32'd20250);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; redirect = 1'b0;
    in_pc = '0; in_uop = '0; in_br = 1'b0; in_taken = 1'b0; in_tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R2 reset state", {out_valid, in_ready}, 2'b01);
    chk(fe_en == 3'b111 && fe_gate == 3'b000, "R8 reset front open", fe_en, 3'b111);
    @(negedge clk);

    // R1 and R2: random stream that must never arm; also back-pressure.
    for (int i = 0; i < 60; i++) begin
      pc = 16'($urandom_range(64, 16'hEF00));
      case ($urandom_range(0, 3))
        0: pass_op(pc, 1'b0, 1'b0, 16'h0, "R1 plain");
        1: pass_op(pc, 1'b1, 1'b0, pc - 16'd3, "R1 not-taken back");
        2: pass_op(pc, 1'b1, 1'b1, pc + 16'($urandom_range(1, 200)), "R1 forward");
        default: begin
          in_valid = $urandom_range(0, 1); out_ready = 1'b0; in_pc = pc;
          in_br = 1'b1; in_taken = 1'b1; in_tgt = pc - 16'd2; in_uop = uop_of(pc);
          #1;
          chk(!in_ready && out_valid == in_valid, "R2 back-pressure", in_ready, 0);
          @(negedge clk);
        end
      endcase
    end
    expect_quiet("R1 random stream");

    // Directed loop of four with stalls, then redirect kills it.
    capture(16'h0100, 4);
    replay_run(16'h0100, 4, 14);
    do_redirect("loop4");
    pass_op(16'h0103, 1'b0, 1'b0, 16'h0, "R8 after flush");
    expect_quiet("R8 buffer dropped");

    // R10: self-loop and exact-depth body.
    capture(16'h0200, 1);
    replay_run(16'h0200, 1, 5);
    do_redirect("self");
    capture(16'h0300, DEPTH);
    replay_run(16'h0300, DEPTH, DEPTH + 6);
    do_redirect("full");

    // R10: body one longer than depth never arms.
    pass_op(16'h0400 + 16'(DEPTH), 1'b1, 1'b1, 16'h0400, "R10 too long");
    for (int k = 0; k <= DEPTH; k++)
      pass_op(16'h0400 + 16'(k), k == DEPTH, k == DEPTH, 16'h0400, "R10 body");
    expect_quiet("R10 over depth");

    // R3: gap in the body drops the capture.
    pass_op(16'h0507, 1'b1, 1'b1, 16'h0500, "R3 arm");
    pass_op(16'h0500, 1'b0, 1'b0, 16'h0, "R3 body");
    pass_op(16'h0502, 1'b0, 1'b0, 16'h0, "R3 gap");
    for (int k = 3; k < 7; k++) pass_op(16'h0500 + 16'(k), 1'b0, 1'b0, 16'h0, "R3 tail");
    pass_op(16'h0507, 1'b0, 1'b0, 16'h0, "R3 end plain");
    expect_quiet("R3 broken capture");

    // R4: loop end reached but branch not taken.
    pass_op(16'h0602, 1'b1, 1'b1, 16'h0600, "R4 arm");
    pass_op(16'h0600, 1'b0, 1'b0, 16'h0, "R4 body");
    pass_op(16'h0601, 1'b0, 1'b0, 16'h0, "R4 body");
    pass_op(16'h0602, 1'b1, 1'b0, 16'h0600, "R4 exit");
    expect_quiet("R4 non-closing end");

    // R9: redirect mid-capture; the closing branch only re-arms.
    pass_op(16'h0703, 1'b1, 1'b1, 16'h0700, "R9 arm");
    pass_op(16'h0700, 1'b0, 1'b0, 16'h0, "R9 body");
    do_redirect("R9 mid");
    pass_op(16'h0701, 1'b0, 1'b0, 16'h0, "R9 body");
    pass_op(16'h0702, 1'b0, 1'b0, 16'h0, "R9 body");
    pass_op(16'h0703, 1'b1, 1'b1, 16'h0700, "R9 rearm");
    expect_quiet("R9 capture discarded");
    do_redirect("R9 clean");

    // Random loops with random stall patterns.
    for (int i = 0; i < 12; i++) begin
      h   = 16'($urandom_range(0, 16'hE000));
      len = $urandom_range(1, DEPTH);
      nst = $urandom_range(len, 3 * len + 5);
      capture(h, len);
      replay_run(h, len, nst);
      do_redirect("R5 random loop");
      expect_quiet("R8 random loop");
    end

    summary();
  end
endmodule